// File: doc/BRIEF.md
# SDIO Card Interrupt Detector

This block sits on the host side of an SD bus. It watches the DAT1 line for an interrupt request from an SDIO card and sends a detected request to one of several interrupt outputs. A low level on DAT1 means the card is asking for service. DAT1 first passes through a resynchronizer of `SYNC_STAGES` flops. The request is then held in a sticky pending flag until the host clears it.

In 1-bit bus mode DAT1 carries nothing but the interrupt, so it is watched on every cycle. In 4-bit bus mode DAT1 also carries data, so the level is sampled only while an interrupt window is open. A window state machine tracks that window. It uses strobes from the surrounding controller: one when a data packet finishes, and one when the end bit of a command has been received, together with a flag that says whether that command has a data transfer. The window FSM has three states:

- `W_OPEN`: the window is open. No transfer is in flight.
- `W_BUSY`: a data transfer is pending or running, and DAT1 is ignored.
- `W_GAP`: the packet has finished, and the FSM counts `GAP_CYCLES` clocks before it reopens the window.

The window FSM has these transitions:

- `W_OPEN` to `W_BUSY` on a command end with data.
- `W_BUSY` to `W_GAP` on packet done.
- `W_GAP` to `W_OPEN` when the count expires.
- `W_GAP` to `W_BUSY` on a command end with data.
- Any state to `W_OPEN` when the bus mode changes.

The flag FSM has two states, `F_IDLE` and `F_PEND`:

- `F_IDLE` to `F_PEND` when DAT1 is seen low with the window open and no clear is present.
- `F_PEND` to `F_IDLE` on a clear.

Top module: `sdio_irq_detect`

## Requirements
- R1: While reset is asserted, and right after it, `card_irq_o` is 0 and every bit of `irq_o` is 0.
- R2: In 1-bit mode (`mode_4b_i`=0), DAT1 held low sets `card_irq_o` on the third rising edge after DAT1 falls. This is two synchronizer edges plus the flag edge. The data and command strobes have no effect in this mode.
- R3: Once `card_irq_o` is set, it stays 1 after DAT1 returns high, until `irq_clr_i` is sampled high. A clear with DAT1 high leaves it at 0.
- R4: A clear has priority over a detection in the same cycle, so the flag reads 0 after the clear edge. If DAT1 is still low with the window open, the flag reads 1 again after the next edge.
- R5: In 4-bit mode, after reset and with no transfer in flight, the window is open, and a low DAT1 is detected with the same latency as in R2.
- R6: In 4-bit mode, a command end strobe with `cmd_has_data_i`=1 closes the window, and a low DAT1 is then ignored. A command end strobe with `cmd_has_data_i`=0 leaves an open window open.
- R7: In 4-bit mode, after `pkt_done_i` is sampled on edge k, the window is open from edge k+`GAP_CYCLES` on. With DAT1 already low, `card_irq_o` reads 1 first after edge k+`GAP_CYCLES`+1, and 0 at all edges before that.
- R8: A change of `mode_4b_i` returns the window FSM to `W_OPEN` and clears its gap counter, whatever transfer state it held.
- R9: While the flag is set and `irq_en_i`=1, exactly `irq_o[irq_sel_i]` is 1 and every other bit is 0, and a change of `irq_sel_i` moves the output in the same cycle. At no time is more than one bit of `irq_o` high.
- R10: While `irq_en_i`=0, `irq_o` is all 0, but detections still set `card_irq_o`. Raising `irq_en_i` drives the selected line at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dat1_i | input | 1 | DAT1 level from the card, asynchronous |
| mode_4b_i | input | 1 | 1 selects 4-bit bus mode, 0 selects 1-bit mode |
| pkt_done_i | input | 1 | One-cycle strobe when a data packet completes |
| cmd_end_i | input | 1 | One-cycle strobe when a command end bit is received |
| cmd_has_data_i | input | 1 | Qualifies `cmd_end_i`: the command carries a data transfer |
| irq_en_i | input | 1 | Enables the steered interrupt outputs |
| irq_clr_i | input | 1 | Clears the pending flag |
| irq_sel_i | input | SEL_W | Index of the output line to drive |
| card_irq_o | output | 1 | Sticky pending interrupt flag |
| irq_o | output | N_IRQ | Steered interrupt lines, at most one high |

## Verification
Two events can land in one cycle: a host clear and a fresh detection. Both happen when DAT1 is still held low inside an open window. The bench provokes this by pulsing `irq_clr_i` while the card keeps DAT1 low. It judges the result by seeing the flag read 0 after the clear edge and 1 after the next edge, which shows that the clear won and that the request was not lost. A second collision is a mode change arriving while the window FSM sits in `W_BUSY`. The bench checks this one by showing that a low DAT1 is detected straight after the bus returns to 4-bit mode.

// File: rtl/sdio_irq_pkg.sv
package sdio_irq_pkg;

    typedef enum logic [1:0] {
        W_OPEN = 2'd0,
        W_BUSY = 2'd1,
        W_GAP  = 2'd2
    } win_state_e;

    typedef enum logic {
        F_IDLE = 1'b0,
        F_PEND = 1'b1
    } flag_state_e;

endpackage

// File: rtl/sdio_irq_sync.sv
module sdio_irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] stage_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= 1'b1;
                    else        stage_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= 1'b1;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/sdio_irq_window.sv
module sdio_irq_window
    import sdio_irq_pkg::*;
#(
    parameter int GAP_CYCLES = 2,
    localparam int CNT_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES + 1) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_4b_i,
    input  logic pkt_done_i,
    input  logic cmd_end_i,
    input  logic cmd_has_data_i,
    output logic open_o
);

    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYCLES - 1);

    win_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             mode_q;
    logic             mode_chg;
    logic             data_cmd;

    assign mode_chg = (mode_4b_i != mode_q);
    assign data_cmd = cmd_end_i && cmd_has_data_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= W_OPEN;
            cnt_q   <= '0;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            mode_q  <= mode_4b_i;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (mode_chg) begin
            state_d = W_OPEN;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                W_OPEN: begin
                    if (data_cmd) state_d = W_BUSY;
                end
                W_BUSY: begin
                    if (pkt_done_i) begin
                        state_d = W_GAP;
                        cnt_d   = '0;
                    end
                end
                W_GAP: begin
                    if (data_cmd) begin
                        state_d = W_BUSY;
                        cnt_d   = '0;
                    end else if (cnt_q == GAP_LAST) begin
                        state_d = W_OPEN;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_d = W_OPEN;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // Output logic
    always_comb begin
        open_o = (!mode_4b_i) || (state_q == W_OPEN);
    end

    // R8: a mode change returns the window to open with a cleared counter
    a_r8_mode_reset: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (state_q == W_OPEN && cnt_q == '0));

    // R6: a busy window stays closed until the packet completes
    a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_chg && state_q == W_BUSY && !pkt_done_i) |=> (state_q == W_BUSY));

    // R7: packet completion starts the gap
    a_r7_gap_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_chg && state_q == W_BUSY && pkt_done_i) |=> (state_q == W_GAP));

    // R6: a command without data keeps an open window open
    a_r6_nodata_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_chg && state_q == W_OPEN && !data_cmd) |=> (state_q == W_OPEN));

endmodule

// File: rtl/sdio_irq_flag.sv
module sdio_irq_flag
    import sdio_irq_pkg::*;
#(
    parameter int N_IRQ = 4,
    localparam int SEL_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dat1_s_i,
    input  logic             win_open_i,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             flag_o,
    output logic [N_IRQ-1:0] irq_o
);

    flag_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= F_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            F_IDLE: begin
                if (!clr_i && win_open_i && !dat1_s_i) state_d = F_PEND;
            end
            F_PEND: begin
                if (clr_i) state_d = F_IDLE;
            end
            default: state_d = F_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        flag_o = (state_q == F_PEND);
    end

    genvar g;
    generate
        for (g = 0; g < N_IRQ; g++) begin : g_line
            assign irq_o[g] = flag_o && en_i && (sel_i == SEL_W'(g));
        end
    endgenerate

    // R4: a clear always wins over a detection in the same cycle
    a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !flag_o);

    // R3: a pending flag holds until cleared
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);

    // R6: a closed window cannot raise the flag
    a_r6_closed_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !win_open_i) |=> !flag_o);

    // R9: never more than one line driven
    a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o));

endmodule

// File: rtl/sdio_irq_detect.sv
module sdio_irq_detect
    import sdio_irq_pkg::*;
#(
    parameter int N_IRQ       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int GAP_CYCLES  = 2,
    localparam int SEL_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dat1_i,
    input  logic             mode_4b_i,
    input  logic             pkt_done_i,
    input  logic             cmd_end_i,
    input  logic             cmd_has_data_i,
    input  logic             irq_en_i,
    input  logic             irq_clr_i,
    input  logic [SEL_W-1:0] irq_sel_i,
    output logic             card_irq_o,
    output logic [N_IRQ-1:0] irq_o
);

    logic dat1_s;
    logic win_open;

    sdio_irq_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (dat1_i),
        .q_o   (dat1_s)
    );

    sdio_irq_window #(
        .GAP_CYCLES (GAP_CYCLES)
    ) u_window (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_4b_i      (mode_4b_i),
        .pkt_done_i     (pkt_done_i),
        .cmd_end_i      (cmd_end_i),
        .cmd_has_data_i (cmd_has_data_i),
        .open_o         (win_open)
    );

    sdio_irq_flag #(
        .N_IRQ (N_IRQ)
    ) u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .dat1_s_i   (dat1_s),
        .win_open_i (win_open),
        .clr_i      (irq_clr_i),
        .en_i       (irq_en_i),
        .sel_i      (irq_sel_i),
        .flag_o     (card_irq_o),
        .irq_o      (irq_o)
    );

    // R10: a steered line is only ever high with a pending flag behind it
    a_r10_line_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o != '0) |-> card_irq_o);

    // R2: in 1-bit mode the flag rises only after DAT1 was seen low
    a_r2_rise_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_irq_o) |-> !$past(dat1_s));

endmodule

// File: tb/sdio_irq_detect_bench.sv
module sdio_irq_detect_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       dat1, mode_4b, pkt_done, cmd_end, cmd_has_data;
    logic       irq_en, irq_clr;
    logic [1:0] irq_sel;
    logic       card_irq;
    logic [3:0] irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    sdio_irq_detect u_sdio_irq_detect (
        .clk            (clk),
        .rst_n          (rst_n),
        .dat1_i         (dat1),
        .mode_4b_i      (mode_4b),
        .pkt_done_i     (pkt_done),
        .cmd_end_i      (cmd_end),
        .cmd_has_data_i (cmd_has_data),
        .irq_en_i       (irq_en),
        .irq_clr_i      (irq_clr),
        .irq_sel_i      (irq_sel),
        .card_irq_o     (card_irq),
        .irq_o          (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic m4);
        rst_n = 1'b0; dat1 = 1'b1; mode_4b = m4; pkt_done = 1'b0;
        cmd_end = 1'b0; cmd_has_data = 1'b0; irq_en = 1'b1; irq_clr = 1'b0;
        irq_sel = 2'd2;
        step(3);
        rst_n = 1'b1;
        step(2);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; dat1 = 1'b0; mode_4b = 1'b0; pkt_done = 1'b0;
        cmd_end = 1'b0; cmd_has_data = 1'b0; irq_en = 1'b1; irq_clr = 1'b0;
        irq_sel = 2'd1;
        step(4);
        check("R1 flag in reset", card_irq, 0);
        check("R1 lines in reset", irq, 0);
        dat1 = 1'b1;
        rst_n = 1'b1;
        step(1);
        check("R1 flag after reset", card_irq, 0);
        check("R1 lines after reset", irq, 0);
    endtask

    task automatic t_onebit;
        do_reset(1'b0);
        cmd_end = 1'b1; cmd_has_data = 1'b1;
        step(1);
        cmd_end = 1'b0; cmd_has_data = 1'b0;
        dat1 = 1'b0;
        step(2);
        check("R2 not yet after two edges", card_irq, 0);
        step(1);
        check("R2 set on third edge", card_irq, 1);
        check("R9 line 2 selected", irq, 4'b0100);
    endtask

    task automatic t_sticky_clear;
        dat1 = 1'b1;
        step(5);
        check("R3 sticky after DAT1 high", card_irq, 1);
        irq_clr = 1'b1;
        step(1);
        irq_clr = 1'b0;
        step(1);
        check("R3 cleared with DAT1 high", card_irq, 0);
        step(3);
        check("R3 stays clear", card_irq, 0);
        dat1 = 1'b0;
        step(4);
        check("R4 flag set before clear", card_irq, 1);
        irq_clr = 1'b1;
        step(1);
        irq_clr = 1'b0;
        check("R4 clear wins", card_irq, 0);
        step(1);
        check("R4 sets again next cycle", card_irq, 1);
    endtask

    task automatic t_idle4;
        do_reset(1'b1);
        dat1 = 1'b0;
        step(2);
        check("R5 not yet", card_irq, 0);
        step(1);
        check("R5 idle window detects", card_irq, 1);
    endtask

    task automatic t_nodata;
        do_reset(1'b1);
        cmd_end = 1'b1; cmd_has_data = 1'b0;
        step(1);
        cmd_end = 1'b0;
        dat1 = 1'b0;
        step(3);
        check("R6 no-data command keeps window open", card_irq, 1);
    endtask

    task automatic t_closed_reopen;
        do_reset(1'b1);
        cmd_end = 1'b1; cmd_has_data = 1'b1;
        step(1);
        cmd_end = 1'b0; cmd_has_data = 1'b0;
        dat1 = 1'b0;
        step(6);
        check("R6 closed window ignores DAT1", card_irq, 0);
        pkt_done = 1'b1;
        step(1);
        pkt_done = 1'b0;
        check("R7 edge k", card_irq, 0);
        step(1);
        check("R7 edge k+1", card_irq, 0);
        step(1);
        check("R7 edge k+2", card_irq, 0);
        step(1);
        check("R7 edge k+3 detected", card_irq, 1);
    endtask

    task automatic t_mode_change;
        do_reset(1'b1);
        cmd_end = 1'b1; cmd_has_data = 1'b1;
        step(1);
        cmd_end = 1'b0; cmd_has_data = 1'b0;
        mode_4b = 1'b0;
        step(1);
        mode_4b = 1'b1;
        step(1);
        dat1 = 1'b0;
        step(2);
        check("R8 not yet", card_irq, 0);
        step(1);
        check("R8 window reopened by mode change", card_irq, 1);
    endtask

    task automatic t_steer_mask;
        do_reset(1'b0);
        irq_en = 1'b0;
        dat1 = 1'b0;
        step(3);
        check("R10 flag records while masked", card_irq, 1);
        check("R10 lines masked", irq, 0);
        irq_en = 1'b1;
        #1;
        check("R10 unmask drives line", irq, 4'b0100);
        irq_sel = 2'd0;
        #1;
        check("R9 select moves to line 0", irq, 4'b0001);
        irq_sel = 2'd3;
        #1;
        check("R9 select moves to line 3", irq, 4'b1000);
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_onebit();
        t_sticky_clear();
        t_idle4();
        t_nodata();
        t_closed_reopen();
        t_mode_change();
        t_steer_mask();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule